// File: doc/BRIEF.md
# Interrupt Priority and Acknowledge Unit

This unit sits between the interrupt sources of a processor core and the core itself. It records incoming requests in a vector-indexed request set and tracks which vectors the core is servicing in an in-service set. For each request it also remembers whether it was level- or edge-triggered. It derives a processor priority from a software-written task priority and the highest vector in service. It offers the core the highest pending vector only when that vector's 16-vector priority class beats the processor priority.

The core takes the offered vector with an acknowledge strobe. When the handler is finished, the core sends an end-of-interrupt strobe. That strobe retires the highest in-service vector. The unit then broadcasts the retired vector and its trigger mode for one cycle, so that a downstream controller can re-arm level-sensitive lines. The vector sets are held as words of 32 bits. The highest-set-bit searches are done per word and then across the words.

Top module: `intr_prio_unit`

## Requirements
- R1: After reset the request, in-service and trigger-mode sets and the task priority are all clear. `procPrio` reads 0, `intPending` is 0 and `eoiValid` is 0.
- R2: An accepted request whose request bit was clear sets that bit. It writes the trigger-mode bit to 1 when `acceptLevel` is 1 and to 0 otherwise. `acceptTaken` is 1 in that same cycle, and only when the request bit was previously clear.
- R3: `procPrio` equals the full task priority when task-priority bits [7:4] are at least bits [7:4] of the highest in-service vector, where an empty in-service set counts as vector 0. Otherwise it equals that vector with bits [3:0] cleared. It reflects register state combinationally.
- R4: `intPending` is 1, with `intVector` set to the highest pending vector, only when both enables are high, the request set is non-empty, and that vector with bits [3:0] cleared is strictly greater than `procPrio`.
- R5: `ackStrobe` while `intPending` is 1 moves the presented vector from the request set into the in-service set at the next edge. `ackStrobe` while `intPending` is 0 changes nothing.
- R6: `eoiStrobe` with a non-empty in-service set clears the highest in-service bit and clears its trigger-mode bit. In the following cycle it drives `eoiValid`=1, `eoiVector`= that vector, and `eoiLevel`= the trigger-mode bit it had before the clear.
- R7: `eoiStrobe` while the in-service set is empty changes no state and leaves `eoiValid` at 0.
- R8: A request is considered only when `hwEnable` and `swEnable` are both 1 and `acceptMode` is 0 (fixed) or 1 (lowest priority). Any other request leaves every set unchanged and returns `acceptTaken`=0.
- R9: A level-triggered request whose request bit is already set is discarded, and its trigger-mode bit is left unchanged. An edge-triggered request on an already-set bit returns 0 but rewrites the trigger-mode bit to 0.
- R10: Events in one cycle combine as follows. Acknowledge clears its request bit first, then an accepted request sets its bit. This re-arms the vector unless R9 discards the request. End-of-interrupt clears its trigger-mode bit before an accepted request writes one. `acceptTaken` is always judged on the register state before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hwEnable | input | 1 | Hardware enable of the unit |
| swEnable | input | 1 | Software enable of the unit |
| acceptValid | input | 1 | A request is offered this cycle |
| acceptVector | input | 8 | Vector of the offered request |
| acceptLevel | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| acceptMode | input | 3 | Delivery kind; 0 fixed, 1 lowest priority, others not handled |
| acceptTaken | output | 1 | Request newly set this cycle |
| tprWrite | input | 1 | Write strobe for the task priority |
| tprData | input | 8 | New task priority |
| ackStrobe | input | 1 | Core takes the presented vector |
| eoiStrobe | input | 1 | Core finished the highest in-service vector |
| intPending | output | 1 | A deliverable interrupt is presented |
| intVector | output | 8 | Presented vector |
| procPrio | output | 8 | Current processor priority |
| eoiValid | output | 1 | End-of-interrupt broadcast valid |
| eoiVector | output | 8 | Retired vector |
| eoiLevel | output | 1 | Retired vector was level-triggered |

## Verification
The bench builds the unit with its defaults: 256 vectors split into eight 32-bit words. This puts the word seams at vectors 31/32 and 223/224 within reach of both priority searches, along with the top vector 255. Random traffic over all 256 vectors, with biased task-priority writes, makes the in-service class and the task-priority class overtake each other in both directions. Directed cases cover the strict class comparison at equality, duplicate level and edge requests, retirement with an empty in-service set, and an acknowledge that collides with a request for the same vector.

// File: rtl/intr_pkg.sv
package intr_pkg;

  // Delivery kinds handled by this unit
  localparam logic [2:0] MODE_FIXED  = 3'd0;
  localparam logic [2:0] MODE_LOWEST = 3'd1;

  // Strobes from control to datapath
  typedef struct packed {
    logic irrSet;    // set request bit of acceptVector
    logic tmrWrite;  // write trigger-mode bit of acceptVector
    logic tmrLevel;  // value written to trigger-mode bit
    logic ackDo;     // move presented vector into service
    logic eoiDo;     // retire highest in-service vector
  } ctrlStrobe_t;

endpackage

// File: rtl/prio_find.sv
module prio_find #(
  parameter int N      = 256,
  parameter int WORD_W = 32
) (
  input  logic [N-1:0]         bits,
  output logic                 found,
  output logic [$clog2(N)-1:0] index
);
  localparam int NW = N / WORD_W;
  localparam int IW = $clog2(WORD_W);
  localparam int SW = $clog2(NW);

  logic [NW-1:0] wordHit;
  logic [IW-1:0] wordIdx [NW];

  // Highest set bit inside each word
  for (genvar w = 0; w < NW; w++) begin : g_word
    always_comb begin
      wordHit[w] = 1'b0;
      wordIdx[w] = '0;
      for (int i = 0; i < WORD_W; i++) begin
        if (bits[w*WORD_W + i]) begin
          wordHit[w] = 1'b1;
          wordIdx[w] = IW'(i);
        end
      end
    end
  end

  // Highest word holding a set bit
  logic [SW-1:0] wordSel;
  always_comb begin
    wordSel = '0;
    for (int w = 0; w < NW; w++) begin
      if (wordHit[w]) wordSel = SW'(w);
    end
  end

  assign found = |wordHit;
  assign index = {wordSel, wordIdx[wordSel]};
endmodule

// File: rtl/intr_control.sv
module intr_control
  import intr_pkg::*;
(
  input  logic        hwEnable,
  input  logic        swEnable,
  input  logic        acceptValid,
  input  logic        acceptLevel,
  input  logic [2:0]  acceptMode,
  input  logic        ackStrobe,
  input  logic        eoiStrobe,
  input  logic        irrHit,      // request bit of acceptVector before the edge
  input  logic        isrFound,    // in-service set non-empty
  input  logic        rawPresent,  // priority test passed
  output ctrlStrobe_t strobe,
  output logic        acceptTaken,
  output logic        intPending
);
  logic unitOn;
  logic modeOk;
  logic acceptOk;
  logic dupLevel;

  assign unitOn   = hwEnable & swEnable;
  assign modeOk   = (acceptMode == MODE_FIXED) || (acceptMode == MODE_LOWEST);
  assign acceptOk = acceptValid & modeOk & unitOn;
  assign dupLevel = irrHit & acceptLevel;

  assign intPending = rawPresent & unitOn;

  always_comb begin
    strobe          = '0;
    strobe.irrSet   = acceptOk & ~dupLevel;
    strobe.tmrWrite = acceptOk & ~dupLevel;
    strobe.tmrLevel = acceptLevel;
    strobe.ackDo    = ackStrobe & intPending;
    strobe.eoiDo    = eoiStrobe & isrFound;
  end

  assign acceptTaken = acceptOk & ~irrHit;
endmodule

// File: rtl/intr_datapath.sv
module intr_datapath
  import intr_pkg::*;
#(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  ctrlStrobe_t                strobe,
  input  logic [$clog2(NUM_VEC)-1:0] acceptVector,
  input  logic                       tprWrite,
  input  logic [$clog2(NUM_VEC)-1:0] tprData,
  output logic                       irrHit,
  output logic                       isrFound,
  output logic                       rawPresent,
  output logic [$clog2(NUM_VEC)-1:0] presentVector,
  output logic [$clog2(NUM_VEC)-1:0] procPrio,
  output logic                       eoiValid,
  output logic [$clog2(NUM_VEC)-1:0] eoiVector,
  output logic                       eoiLevel
);
  localparam int VW = $clog2(NUM_VEC);
  localparam int CW = VW - 4;   // width of a 16-vector class number

  logic [NUM_VEC-1:0] irr, isr, tmr;
  logic [VW-1:0]      tpr;

  logic          irrFound;
  logic [VW-1:0] irrTop, isrTop, isrEff;

  prio_find #(.N(NUM_VEC), .WORD_W(WORD_W)) u_irrFind (
    .bits(irr), .found(irrFound), .index(irrTop)
  );
  prio_find #(.N(NUM_VEC), .WORD_W(WORD_W)) u_isrFind (
    .bits(isr), .found(isrFound), .index(isrTop)
  );

  // Processor priority
  logic [CW-1:0] tprClass, isrClass;
  assign isrEff   = isrFound ? isrTop : '0;
  assign tprClass = tpr[VW-1:4];
  assign isrClass = isrEff[VW-1:4];
  assign procPrio = (tprClass >= isrClass) ? tpr : {isrClass, 4'h0};

  // Presentation test
  assign rawPresent    = irrFound && ({irrTop[VW-1:4], 4'h0} > procPrio);
  assign presentVector = irrTop;
  assign irrHit        = irr[acceptVector];

  // One-hot masks
  logic [NUM_VEC-1:0] acceptMask, ackMask, eoiMask;
  assign acceptMask = NUM_VEC'(1) << acceptVector;
  assign ackMask    = strobe.ackDo ? (NUM_VEC'(1) << irrTop) : '0;
  assign eoiMask    = strobe.eoiDo ? (NUM_VEC'(1) << isrTop) : '0;

  logic [NUM_VEC-1:0] irrNext, isrNext, tmrNext;
  always_comb begin
    irrNext = irr & ~ackMask;
    if (strobe.irrSet) irrNext = irrNext | acceptMask;

    isrNext = (isr | ackMask) & ~eoiMask;

    tmrNext = tmr & ~eoiMask;
    if (strobe.tmrWrite) begin
      if (strobe.tmrLevel) tmrNext = tmrNext | acceptMask;
      else                 tmrNext = tmrNext & ~acceptMask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr <= '0;
      isr <= '0;
      tmr <= '0;
      tpr <= '0;
    end else begin
      irr <= irrNext;
      isr <= isrNext;
      tmr <= tmrNext;
      if (tprWrite) tpr <= tprData;
    end
  end

  // End-of-interrupt broadcast, one cycle after the strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoiValid  <= 1'b0;
      eoiVector <= '0;
      eoiLevel  <= 1'b0;
    end else begin
      eoiValid <= strobe.eoiDo;
      if (strobe.eoiDo) begin
        eoiVector <= isrTop;
        eoiLevel  <= tmr[isrTop];
      end
    end
  end
endmodule

// File: rtl/intr_prio_unit.sv
module intr_prio_unit
  import intr_pkg::*;
#(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hwEnable,
  input  logic       swEnable,
  input  logic       acceptValid,
  input  logic [7:0] acceptVector,
  input  logic       acceptLevel,
  input  logic [2:0] acceptMode,
  output logic       acceptTaken,
  input  logic       tprWrite,
  input  logic [7:0] tprData,
  input  logic       ackStrobe,
  input  logic       eoiStrobe,
  output logic       intPending,
  output logic [7:0] intVector,
  output logic [7:0] procPrio,
  output logic       eoiValid,
  output logic [7:0] eoiVector,
  output logic       eoiLevel
);
  ctrlStrobe_t strobe;
  logic irrHit, isrFound, rawPresent;

  intr_control u_ctrl (
    .hwEnable    (hwEnable),
    .swEnable    (swEnable),
    .acceptValid (acceptValid),
    .acceptLevel (acceptLevel),
    .acceptMode  (acceptMode),
    .ackStrobe   (ackStrobe),
    .eoiStrobe   (eoiStrobe),
    .irrHit      (irrHit),
    .isrFound    (isrFound),
    .rawPresent  (rawPresent),
    .strobe      (strobe),
    .acceptTaken (acceptTaken),
    .intPending  (intPending)
  );

  intr_datapath #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_dp (
    .clk           (clk),
    .rst_n         (rst_n),
    .strobe        (strobe),
    .acceptVector  (acceptVector),
    .tprWrite      (tprWrite),
    .tprData       (tprData),
    .irrHit        (irrHit),
    .isrFound      (isrFound),
    .rawPresent    (rawPresent),
    .presentVector (intVector),
    .procPrio      (procPrio),
    .eoiValid      (eoiValid),
    .eoiVector     (eoiVector),
    .eoiLevel      (eoiLevel)
  );
endmodule

// File: rtl/intr_prio_unit_chk.sv
module intr_prio_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hwEnable,
  input logic       swEnable,
  input logic       acceptValid,
  input logic       acceptTaken,
  input logic       tprWrite,
  input logic [7:0] tprData,
  input logic       ackStrobe,
  input logic       eoiStrobe,
  input logic       intPending,
  input logic [7:0] intVector,
  input logic [7:0] procPrio,
  input logic       eoiValid
);
  // R6
  eoi_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoiValid |-> $past(eoiStrobe));

  // R8
  taken_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acceptTaken |-> (acceptValid && hwEnable && swEnable));

  // R4
  pending_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hwEnable && swEnable) |-> !intPending);

  // R5
  ack_raises_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ackStrobe && intPending) |=> (procPrio[7:4] >= $past(intVector[7:4])));

  // R3
  prio_floor_tpr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tprWrite |=> (procPrio >= $past(tprData)));
endmodule

bind intr_prio_unit intr_prio_unit_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hwEnable    (hwEnable),
  .swEnable    (swEnable),
  .acceptValid (acceptValid),
  .acceptTaken (acceptTaken),
  .tprWrite    (tprWrite),
  .tprData     (tprData),
  .ackStrobe   (ackStrobe),
  .eoiStrobe   (eoiStrobe),
  .intPending  (intPending),
  .intVector   (intVector),
  .procPrio    (procPrio),
  .eoiValid    (eoiValid)
);

// File: tb/intr_prio_unit_tb.sv
`timescale 1ns/1ps
module intr_prio_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hwEnable = 1'b1, swEnable = 1'b1;
  logic       acceptValid = 1'b0, acceptLevel = 1'b0;
  logic [7:0] acceptVector = '0;
  logic [2:0] acceptMode = '0;
  logic       tprWrite = 1'b0;
  logic [7:0] tprData = '0;
  logic       ackStrobe = 1'b0, eoiStrobe = 1'b0;
  logic       acceptTaken, intPending, eoiValid, eoiLevel;
  logic [7:0] intVector, procPrio, eoiVector;

  always #5 clk = ~clk;

  intr_prio_unit u_dut (
    .clk(clk), .rst_n(rst_n), .hwEnable(hwEnable), .swEnable(swEnable),
    .acceptValid(acceptValid), .acceptVector(acceptVector),
    .acceptLevel(acceptLevel), .acceptMode(acceptMode),
    .acceptTaken(acceptTaken), .tprWrite(tprWrite), .tprData(tprData),
    .ackStrobe(ackStrobe), .eoiStrobe(eoiStrobe), .intPending(intPending),
    .intVector(intVector), .procPrio(procPrio), .eoiValid(eoiValid),
    .eoiVector(eoiVector), .eoiLevel(eoiLevel)
  );

  int checks = 0;
  int failures = 0;

  // Reference state
  logic [255:0] irrM = '0, isrM = '0, tmrM = '0;
  logic [7:0]   tprM = '0;
  logic         expEoiValid = 1'b0, expEoiLevel = 1'b0;
  logic [7:0]   expEoiVector = '0;

  task automatic check(input int actual, input int expected, input string tag);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, actual, expected, $time);
    end
  endtask

  function automatic int highest(input logic [255:0] b);
    int r = -1;
    for (int i = 0; i < 256; i++) if (b[i]) r = i;
    return r;
  endfunction

  function automatic logic [7:0] refPrio();
    int top = highest(isrM);
    logic [7:0] iv = (top < 0) ? 8'h00 : 8'(top);
    return (tprM[7:4] >= iv[7:4]) ? tprM : {iv[7:4], 4'h0};
  endfunction

  function automatic logic refPending();
    int top = highest(irrM);
    logic [7:0] tv = 8'(top);
    return hwEnable && swEnable && top >= 0 && ({tv[7:4], 4'h0} > refPrio());
  endfunction

  function automatic logic refAcceptOk();
    return acceptValid && hwEnable && swEnable && (acceptMode <= 3'd1);
  endfunction

  // Checks before the edge, then the edge, then reference update
  task automatic cycle();
    logic pend, ok, hit, ackDo, eoiDo;
    int irrTop, isrTop;
    #1;
    pend = refPending();
    check(int'(procPrio), int'(refPrio()), "R3");
    check(int'(intPending), int'(pend), "R4");
    if (pend) check(int'(intVector), highest(irrM), "R4");
    check(int'(acceptTaken), int'(refAcceptOk() && !irrM[acceptVector]), "R2");
    check(int'(eoiValid), int'(expEoiValid), "R6");
    if (expEoiValid) begin
      check(int'(eoiVector), int'(expEoiVector), "R6");
      check(int'(eoiLevel), int'(expEoiLevel), "R6");
    end
    ok = refAcceptOk();
    hit = irrM[acceptVector];
    irrTop = highest(irrM);
    isrTop = highest(isrM);
    ackDo = ackStrobe && pend;
    eoiDo = eoiStrobe && (isrTop >= 0);
    @(posedge clk);
    expEoiValid = eoiDo;
    if (eoiDo) begin
      expEoiVector = 8'(isrTop);
      expEoiLevel  = tmrM[isrTop];
      tmrM[isrTop] = 1'b0;
      isrM[isrTop] = 1'b0;
    end
    if (ackDo) begin
      irrM[irrTop] = 1'b0;
      isrM[irrTop] = 1'b1;
    end
    if (ok && !(hit && acceptLevel)) begin
      irrM[acceptVector] = 1'b1;
      tmrM[acceptVector] = acceptLevel;
    end
    if (tprWrite) tprM = tprData;
    @(negedge clk);
    acceptValid = 1'b0; tprWrite = 1'b0; ackStrobe = 1'b0; eoiStrobe = 1'b0;
  endtask

  task automatic offer(input logic [7:0] v, input logic lvl, input logic [2:0] m);
    acceptValid = 1'b1; acceptVector = v; acceptLevel = lvl; acceptMode = m;
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check(int'(procPrio), 0, "R1");
    check(int'(intPending), 0, "R1");
    check(int'(eoiValid), 0, "R1");
    @(negedge clk);

    // R8: software enable low, request ignored
    swEnable = 1'b0; offer(8'h40, 1'b0, 3'd0);
    #1 check(int'(acceptTaken), 0, "R8");
    cycle();
    swEnable = 1'b1;
    offer(8'h41, 1'b0, 3'd5);   // unhandled kind
    #1 check(int'(acceptTaken), 0, "R8");
    cycle();
    #1 check(int'(intPending), 0, "R8");

    // R2: fresh edge request
    offer(8'h40, 1'b0, 3'd0);
    cycle();
    #1 check(int'(intPending), 1, "R2");
    check(int'(intVector), 8'h40, "R2");

    // R4: strict class comparison
    tprWrite = 1'b1; tprData = 8'h40; cycle();
    #1 check(int'(intPending), 0, "R4");
    tprWrite = 1'b1; tprData = 8'h3F; cycle();
    #1 check(int'(intPending), 1, "R4");

    // R5: acknowledge
    ackStrobe = 1'b1; cycle();
    #1 check(int'(procPrio), 8'h40, "R5");
    check(int'(intPending), 0, "R5");
    ackStrobe = 1'b1; cycle();          // nothing presented: ignored
    #1 check(int'(procPrio), 8'h40, "R5");

    // R9: duplicate level request
    offer(8'h51, 1'b1, 3'd1); cycle();
    offer(8'h51, 1'b1, 3'd0);
    #1 check(int'(acceptTaken), 0, "R9");
    cycle();
    ackStrobe = 1'b1; cycle();
    eoiStrobe = 1'b1; cycle();
    #1 check(int'(eoiVector), 8'h51, "R9");
    check(int'(eoiLevel), 1, "R9");
    eoiStrobe = 1'b1; cycle();
    #1 check(int'(eoiVector), 8'h40, "R6");
    check(int'(eoiLevel), 0, "R6");
    // R7: retirement with empty in-service set
    eoiStrobe = 1'b1; cycle();
    #1 check(int'(eoiValid), 0, "R7");
    check(int'(procPrio), 8'h3F, "R7");

    // R10: acknowledge collides with request for same vector
    offer(8'h60, 1'b0, 3'd0); cycle();
    ackStrobe = 1'b1; offer(8'h60, 1'b0, 3'd0);
    #1 check(int'(acceptTaken), 0, "R10");
    cycle();
    #1 check(int'(procPrio), 8'h60, "R10");
    eoiStrobe = 1'b1; cycle();
    #1 check(int'(intPending), 1, "R10");
    check(int'(intVector), 8'h60, "R10");
    ackStrobe = 1'b1; cycle();
    eoiStrobe = 1'b1; cycle();

    // Word seams
    offer(8'd31, 1'b1, 3'd0); cycle();
    offer(8'd32, 1'b0, 3'd0); cycle();
    tprWrite = 1'b1; tprData = 8'h00; cycle();
    #1 check(int'(intVector), 32, "R4");

    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      int r;
      hwEnable = ($urandom % 40) != 0;
      swEnable = ($urandom % 40) != 0;
      if (($urandom % 3) != 0) begin
        r = $urandom % 10;
        offer(8'($urandom), 1'($urandom), (r < 8) ? 3'(r % 2) : 3'($urandom));
      end
      if (($urandom % 12) == 0) begin
        tprWrite = 1'b1;
        tprData = (($urandom % 3) == 0) ? 8'($urandom) : 8'($urandom % 96);
      end
      ackStrobe = ($urandom % 3) == 0;
      eoiStrobe = ($urandom % 3) == 0;
      cycle();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule